// File: doc/BRIEF.md
# Management Interrupt Request and Protected Window Controller

This chipset-side controller collects requests for the system management interrupt and drives one active-low request line that goes to every processor core at once. A request can come from an active-low external pin, from an I/O write to the fixed software trigger port 0xB2, or from an I/O write to a trap address that firmware programs. The data byte of a software trigger write is kept for the handler. A sticky per-source status register shows which sources fired. The handler clears it by writing ones.

The processor reports its in-mode state on an active-low status input. The controller opens decode of the protected memory window only while that input is low. It also works out the entry fetch point from a programmable base register: segment, pointer and physical address. Firmware can change the base only while management mode is active. A watchdog flags a handler that stays in the mode too long.

Top module: `mgmt_irq_ctrl`

## Requirements
- R1: Each source sets its own status bit and raises the request: bit 0 for a falling edge on `ext_req_ni` (seen at the outputs three clock edges after the pin falls), bit 1 for an I/O write to port 0xB2, bit 2 for an I/O write to the programmed trap address (reset value 0xFFFF). I/O writes show at the outputs one edge after the write strobe.
- R2: No register write masks the request. Once raised, `smi_n_o` stays low until `in_mode_ni` goes low, and the pending request is dropped on that entry edge.
- R3: A source whose status bit is already set does not raise a new request. Writing a 1 to status bit k (select 2) clears bit k.
- R4: Sources that fire in the same cycle merge into one request, and every one of their status bits is set.
- R5: The data byte of the last port 0xB2 write appears on `cmd_o`.
- R6: `smram_sel_o` is high only when `mem_req_i` is high, `mem_addr_i` is inside the window [0x30000, 0x3FFFF] and `in_mode_ni` is low.
- R7: `entry_cs_o` equals the base shifted right by 4, `entry_ip_o` is 0x8000, and `entry_addr_o` equals base + 0x8000. After reset the base is 0x30000 and the entry address is 0x38000.
- R8: A base write (select 1, low 4 bits forced to zero) takes effect only while `in_mode_ni` is low. At other times it is ignored.
- R9: All bits of `smi_n_o` carry the same value in every cycle.
- R10: If `in_mode_ni` stays low for more than the programmed limit (select 3) of consecutive cycles, `overrun_o` is set and stays set until a 1 is written to status bit 3.
- R11: A fresh request that arrives in the same cycle as mode entry is kept, and it is raised again after the mode exits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_req_ni | input | 1 | External request pin, active low |
| io_wr_i | input | 1 | Single-cycle I/O write strobe |
| io_addr_i | input | 16 | I/O write port address |
| io_data_i | input | 8 | I/O write data byte |
| reg_wr_i | input | 1 | Configuration write strobe |
| reg_sel_i | input | 2 | 0 trap address, 1 base, 2 status clear, 3 timeout limit |
| reg_wdata_i | input | 20 | Configuration write data |
| in_mode_ni | input | 1 | Processor in-mode status, active low |
| mem_req_i | input | 1 | Memory access valid |
| mem_addr_i | input | 24 | Memory access address |
| smi_n_o | output | NUM_CORES | Request to each core, active low |
| src_o | output | 3 | Per-source status bits |
| overrun_o | output | 1 | Sticky handler timeout flag |
| cmd_o | output | 8 | Last software trigger byte |
| smbase_o | output | 20 | Current base register |
| entry_cs_o | output | 16 | Entry code segment |
| entry_ip_o | output | 16 | Entry instruction pointer |
| entry_addr_o | output | 24 | Entry physical fetch address |
| smram_sel_o | output | 1 | Protected window selected |

## Verification
Two events can fall on the same edge: the processor reporting entry, which drops the pending request, and a fresh request, which sets it. The bench provokes this by driving `in_mode_ni` low in the same cycle as a trap-address write while an earlier port request is still pending. It then checks that `smi_n_o` is high during the mode and low again right after exit. A second case writes a status clear in the same cycle as a repeat write to the same source. Here the set must win, so that source's status bit is checked to still be 1.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int NUM_SRC  = 3;
  localparam int SRC_PIN  = 0;
  localparam int SRC_PORT = 1;
  localparam int SRC_TRAP = 2;
  localparam logic [15:0] SW_PORT  = 16'h00B2;
  localparam logic [15:0] ENTRY_IP = 16'h8000;

  typedef enum logic [1:0] {
    SEL_TRAP = 2'd0,
    SEL_BASE = 2'd1,
    SEL_STAT = 2'd2,
    SEL_TMO  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/mgmt_req_merge.sv
module mgmt_req_merge
  import mgmt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ext_req_ni,
  input  logic               io_wr_i,
  input  logic [15:0]        io_addr_i,
  input  logic [7:0]         io_data_i,
  input  logic [15:0]        trap_addr_i,
  input  logic               mode_act_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] src_o,
  output logic               pending_o,
  output logic [7:0]         cmd_o
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0]    sync_q;
  logic [NUM_SRC-1:0] ev, src_q;
  logic               pend_q, mode_q, fresh, rise;
  logic [7:0]         cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SH_W-2:0], ext_req_ni};

  always_comb begin
    ev           = '0;
    ev[SRC_PIN]  = sync_q[SH_W-1] & ~sync_q[SH_W-2];
    ev[SRC_PORT] = io_wr_i && (io_addr_i == SW_PORT);
    ev[SRC_TRAP] = io_wr_i && (io_addr_i == trap_addr_i);
  end

  assign fresh = |(ev & ~src_q);
  assign rise  = mode_act_i & ~mode_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      src_q  <= '0;
      pend_q <= 1'b0;
      mode_q <= 1'b0;
      cmd_q  <= '0;
    end else begin
      src_q  <= (src_q & ~clr_i) | ev;
      mode_q <= mode_act_i;
      if (fresh)     pend_q <= 1'b1;   // set wins over entry clear
      else if (rise) pend_q <= 1'b0;
      if (ev[SRC_PORT]) cmd_q <= io_data_i;
    end

  assign src_o     = src_q;
  assign pending_o = pend_q;
  assign cmd_o     = cmd_q;
endmodule

// File: rtl/mgmt_smram_gate.sv
module mgmt_smram_gate
  import mgmt_pkg::*;
#(
  parameter int                AW       = 24,
  parameter int                SB_W     = 20,
  parameter logic [AW-1:0]     WIN_BASE = 24'h030000,
  parameter logic [AW-1:0]     WIN_SIZE = 24'h010000
) (
  input  logic [SB_W-1:0] smbase_i,
  input  logic            mode_act_i,
  input  logic            mem_req_i,
  input  logic [AW-1:0]   mem_addr_i,
  output logic            sel_o,
  output logic [15:0]     cs_o,
  output logic [15:0]     ip_o,
  output logic [AW-1:0]   entry_o
);
  localparam logic [AW-1:0] WIN_LAST = WIN_BASE + WIN_SIZE - 1;

  logic hit;
  assign hit   = (mem_addr_i >= WIN_BASE) && (mem_addr_i <= WIN_LAST);
  assign sel_o = mem_req_i & hit & mode_act_i;

  assign cs_o    = smbase_i[19:4];
  assign ip_o    = ENTRY_IP;
  assign entry_o = AW'({cs_o, 4'h0}) + AW'(ip_o);
endmodule

// File: rtl/mgmt_watchdog.sv
module mgmt_watchdog #(
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_act_i,
  input  logic [TMO_W-1:0] limit_i,
  input  logic             clr_i,
  output logic             overrun_o
);
  logic [TMO_W-1:0] cnt_q;
  logic             ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      if (!mode_act_i)     cnt_q <= '0;
      else if (~&cnt_q)    cnt_q <= cnt_q + 1'b1;
      if (mode_act_i && cnt_q >= limit_i) ovr_q <= 1'b1;
      else if (clr_i)                     ovr_q <= 1'b0;
    end

  assign overrun_o = ovr_q;
endmodule

// File: rtl/mgmt_irq_ctrl.sv
module mgmt_irq_ctrl
  import mgmt_pkg::*;
#(
  parameter int               NUM_CORES = 4,
  parameter int               AW        = 24,
  parameter int               SB_W      = 20,
  parameter int               TMO_W     = 16,
  parameter logic [SB_W-1:0]  BASE_RST  = 20'h30000,
  parameter logic [TMO_W-1:0] TMO_RST   = 16'd1000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ext_req_ni,
  input  logic                 io_wr_i,
  input  logic [15:0]          io_addr_i,
  input  logic [7:0]           io_data_i,
  input  logic                 reg_wr_i,
  input  logic [1:0]           reg_sel_i,
  input  logic [SB_W-1:0]      reg_wdata_i,
  input  logic                 in_mode_ni,
  input  logic                 mem_req_i,
  input  logic [AW-1:0]        mem_addr_i,
  output logic [NUM_CORES-1:0] smi_n_o,
  output logic [NUM_SRC-1:0]   src_o,
  output logic                 overrun_o,
  output logic [7:0]           cmd_o,
  output logic [SB_W-1:0]      smbase_o,
  output logic [15:0]          entry_cs_o,
  output logic [15:0]          entry_ip_o,
  output logic [AW-1:0]        entry_addr_o,
  output logic                 smram_sel_o
);
  logic               mode_act, pending, stat_wr;
  logic [15:0]        trap_q;
  logic [SB_W-1:0]    base_q;
  logic [TMO_W-1:0]   tmo_q;
  logic [NUM_SRC-1:0] src_clr;

  assign mode_act = ~in_mode_ni;
  assign stat_wr  = reg_wr_i && (reg_sel_i == SEL_STAT);
  assign src_clr  = stat_wr ? reg_wdata_i[NUM_SRC-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      trap_q <= 16'hFFFF;
      base_q <= BASE_RST;
      tmo_q  <= TMO_RST;
    end else if (reg_wr_i) begin
      unique case (reg_sel_e'(reg_sel_i))
        SEL_TRAP: trap_q <= reg_wdata_i[15:0];
        SEL_BASE: if (mode_act) base_q <= {reg_wdata_i[SB_W-1:4], 4'h0};
        SEL_TMO:  tmo_q  <= reg_wdata_i[TMO_W-1:0];
        default:  ;
      endcase
    end

  mgmt_req_merge u_merge (
    .clk_i, .rst_ni, .ext_req_ni, .io_wr_i, .io_addr_i, .io_data_i,
    .trap_addr_i (trap_q),
    .mode_act_i  (mode_act),
    .clr_i       (src_clr),
    .src_o       (src_o),
    .pending_o   (pending),
    .cmd_o       (cmd_o)
  );

  mgmt_smram_gate #(.AW(AW), .SB_W(SB_W)) u_gate (
    .smbase_i   (base_q),
    .mode_act_i (mode_act),
    .mem_req_i, .mem_addr_i,
    .sel_o      (smram_sel_o),
    .cs_o       (entry_cs_o),
    .ip_o       (entry_ip_o),
    .entry_o    (entry_addr_o)
  );

  mgmt_watchdog #(.TMO_W(TMO_W)) u_wdog (
    .clk_i, .rst_ni,
    .mode_act_i (mode_act),
    .limit_i    (tmo_q),
    .clr_i      (stat_wr & reg_wdata_i[NUM_SRC]),
    .overrun_o  (overrun_o)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_bcast
    assign smi_n_o[c] = ~(pending & ~mode_act);
  end

  assign smbase_o = base_q;
endmodule

// File: rtl/mgmt_irq_ctrl_chk.sv
module mgmt_irq_ctrl_chk #(
  parameter int NUM_CORES = 4,
  parameter int AW        = 24,
  parameter int SB_W      = 20
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 in_mode_ni,
  input logic                 reg_wr_i,
  input logic [1:0]           reg_sel_i,
  input logic [SB_W-1:0]      reg_wdata_i,
  input logic [NUM_CORES-1:0] smi_n_o,
  input logic                 overrun_o,
  input logic [SB_W-1:0]      smbase_o,
  input logic [AW-1:0]        entry_addr_o,
  input logic                 smram_sel_o
);
  AST_WINDOW_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_mode_ni |-> !smram_sel_o);                                            // R6
  AST_ENTRY_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_addr_o == AW'(smbase_o) + AW'(24'h8000));                          // R7
  AST_BASE_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_mode_ni |=> $stable(smbase_o));                                       // R8
  AST_BROADCAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(smi_n_o) == 0) || ($countones(smi_n_o) == NUM_CORES));      // R9
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!smi_n_o[0] && in_mode_ni) |=> (!smi_n_o[0] || !in_mode_ni));          // R2
  AST_OVERRUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !(reg_wr_i && reg_sel_i == 2'd2 && reg_wdata_i[3]))
    |=> overrun_o);                                                          // R10
endmodule

bind mgmt_irq_ctrl mgmt_irq_ctrl_chk #(.NUM_CORES(NUM_CORES), .AW(AW), .SB_W(SB_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_mode_ni(in_mode_ni),
  .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i),
  .smi_n_o(smi_n_o), .overrun_o(overrun_o), .smbase_o(smbase_o),
  .entry_addr_o(entry_addr_o), .smram_sel_o(smram_sel_o)
);

// File: tb/sim_mgmt_irq_ctrl.sv
`timescale 1ns/1ps
module sim_mgmt_irq_ctrl;
  localparam int NC = 4;

  logic        clk_i = 0, rst_ni = 0;
  logic        ext_req_ni = 1, io_wr_i = 0, reg_wr_i = 0, in_mode_ni = 1, mem_req_i = 0;
  logic [15:0] io_addr_i = '0;
  logic [7:0]  io_data_i = '0;
  logic [1:0]  reg_sel_i = '0;
  logic [19:0] reg_wdata_i = '0;
  logic [23:0] mem_addr_i = '0;
  logic [NC-1:0] smi_n_o;
  logic [2:0]  src_o;
  logic        overrun_o, smram_sel_o;
  logic [7:0]  cmd_o;
  logic [19:0] smbase_o;
  logic [15:0] entry_cs_o, entry_ip_o;
  logic [23:0] entry_addr_o;

  int n_run = 0, n_fail = 0;

  always #4 clk_i = ~clk_i;

  mgmt_irq_ctrl #(.NUM_CORES(NC)) u0 (.*);

  // {mode_n, addr, expected select}
  localparam logic [25:0] WIN_VEC [8] = '{
    {1'b0, 24'h030000, 1'b1}, {1'b0, 24'h03FFFF, 1'b1},
    {1'b0, 24'h02FFFF, 1'b0}, {1'b0, 24'h040000, 1'b0},
    {1'b1, 24'h030000, 1'b0}, {1'b1, 24'h03ABCD, 1'b0},
    {1'b0, 24'h035555, 1'b1}, {1'b1, 24'h010000, 1'b0}};
  // {io address, expected status bits}
  localparam logic [18:0] IO_VEC [5] = '{
    {16'h00B2, 3'b010}, {16'h0123, 3'b100}, {16'h00B3, 3'b000},
    {16'h0122, 3'b000}, {16'h01B2, 3'b000}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i); io_wr_i = 1; io_addr_i = a; io_data_i = d;
    @(negedge clk_i); io_wr_i = 0;
  endtask

  task automatic reg_write(input logic [1:0] s, input logic [19:0] d);
    @(negedge clk_i); reg_wr_i = 1; reg_sel_i = s; reg_wdata_i = d;
    @(negedge clk_i); reg_wr_i = 0;
  endtask

  task automatic enter_exit(input int n);
    @(negedge clk_i); in_mode_ni = 0;
    repeat (n) @(negedge clk_i);
    in_mode_ni = 1;
    @(negedge clk_i);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R2 reset smi", smi_n_o, 4'hF);
    chk("R1 reset src", src_o, 0);
    chk("R7 reset entry", entry_addr_o, 24'h038000);
    chk("R7 reset cs", entry_cs_o, 16'h3000);
    chk("R7 ip", entry_ip_o, 16'h8000);
    chk("R10 reset overrun", overrun_o, 0);

    reg_write(2'd0, 20'h00123);
    // R1 R5: io vector walk
    foreach (IO_VEC[i]) begin
      reg_write(2'd2, 20'h7);
      io_write(IO_VEC[i][18:3], 8'(i + 8'h40));
      chk("R1 io src", src_o, IO_VEC[i][2:0]);
      chk("R9 io smi", smi_n_o, (IO_VEC[i][2:0] != 0) ? 4'h0 : 4'hF);
      enter_exit(2);
      chk("R2 cleared by entry", smi_n_o, 4'hF);
    end
    chk("R5 cmd byte", cmd_o, 8'h40);

    // R6: window table
    mem_req_i = 1;
    foreach (WIN_VEC[i]) begin
      @(negedge clk_i); in_mode_ni = WIN_VEC[i][25]; mem_addr_i = WIN_VEC[i][24:1];
      #1 chk("R6 window", smram_sel_o, WIN_VEC[i][0]);
    end
    @(negedge clk_i); in_mode_ni = 0; mem_req_i = 0;
    #1 chk("R6 no request", smram_sel_o, 0);
    @(negedge clk_i); in_mode_ni = 1;

    // R1 pin source with sync latency
    reg_write(2'd2, 20'h7);
    @(negedge clk_i); ext_req_ni = 0;
    @(negedge clk_i); @(negedge clk_i);
    chk("R1 pin not yet", src_o, 0);
    @(negedge clk_i);
    chk("R1 pin src", src_o, 3'b001);
    chk("R1 pin smi", smi_n_o, 4'h0);
    ext_req_ni = 1;
    // R2 no mask: config writes do not drop request
    reg_write(2'd0, 20'hFFFFF);
    reg_write(2'd3, 20'hFFFFF);
    reg_write(2'd1, 20'hFFFFF);
    repeat (10) @(negedge clk_i);
    chk("R2 held", smi_n_o, 4'h0);
    @(negedge clk_i); in_mode_ni = 0;
    #1 chk("R2 released on entry", smi_n_o, 4'hF);
    @(negedge clk_i); in_mode_ni = 1;
    @(negedge clk_i);
    chk("R2 dropped after exit", smi_n_o, 4'hF);
    chk("R8 ignored out of mode", smbase_o, 20'h30000);
    reg_write(2'd0, 20'h00123);

    // R3: recorded source does not re-raise
    reg_write(2'd2, 20'h7);
    io_write(16'h00B2, 8'h11);
    enter_exit(1);
    io_write(16'h00B2, 8'h22);
    chk("R3 no re-raise", smi_n_o, 4'hF);
    chk("R5 cmd update", cmd_o, 8'h22);
    reg_write(2'd2, 20'h2);
    chk("R3 w1c", src_o, 0);
    io_write(16'h00B2, 8'h33);
    chk("R3 raised after clear", smi_n_o, 4'h0);
    enter_exit(1);

    // R3 same cycle clear and set: set wins
    @(negedge clk_i); reg_wr_i = 1; reg_sel_i = 2'd2; reg_wdata_i = 20'h2;
    io_wr_i = 1; io_addr_i = 16'h00B2;
    @(negedge clk_i); reg_wr_i = 0; io_wr_i = 0;
    chk("R3 set beats clear", src_o[1], 1);
    enter_exit(1);

    // R4: pin and port in the same cycle
    reg_write(2'd2, 20'h7);
    @(negedge clk_i); ext_req_ni = 0;
    @(negedge clk_i); @(negedge clk_i); io_wr_i = 1; io_addr_i = 16'h00B2;
    @(negedge clk_i); io_wr_i = 0; ext_req_ni = 1;
    chk("R4 merged src", src_o, 3'b011);
    chk("R4 one request", smi_n_o, 4'h0);
    enter_exit(1);
    chk("R4 single entry clears", smi_n_o, 4'hF);

    // R11: fresh request on entry edge
    reg_write(2'd2, 20'h7);
    io_write(16'h00B2, 8'h01);
    @(negedge clk_i); in_mode_ni = 0; io_wr_i = 1; io_addr_i = 16'h0123;
    @(negedge clk_i); io_wr_i = 0;
    chk("R11 masked in mode", smi_n_o, 4'hF);
    @(negedge clk_i); in_mode_ni = 1;
    #1 chk("R11 re-raised", smi_n_o, 4'h0);
    enter_exit(1);

    // R8: base write in mode
    @(negedge clk_i); in_mode_ni = 0;
    reg_wr_i = 1; reg_sel_i = 2'd1; reg_wdata_i = 20'h5000F;
    @(negedge clk_i); reg_wr_i = 0; in_mode_ni = 1;
    chk("R8 base in mode", smbase_o, 20'h50000);
    chk("R7 entry moved", entry_addr_o, 24'h058000);
    chk("R7 cs moved", entry_cs_o, 16'h5000);

    // R10 watchdog
    reg_write(2'd3, 20'd5);
    enter_exit(5);
    chk("R10 at limit", overrun_o, 0);
    enter_exit(7);
    chk("R10 overrun", overrun_o, 1);
    repeat (3) @(negedge clk_i);
    chk("R10 sticky", overrun_o, 1);
    reg_write(2'd2, 20'h8);
    chk("R10 w1c", overrun_o, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule